// File: doc/BRIEF.md
# Subaddress Message Buffer Indexer

This block handles message storage for a single subaddress of a remote terminal on a serial command/response bus. A loaded control word gives a count of buffers that remain. A loaded data pointer gives where the current buffer starts. Each data word received during a message goes out on a RAM write port at the current buffer plus the word's position in the message. When the message completes, the block writes a status word to a fixed status location. That word holds the error flag, the word count and a coarse time tag.

After each good message, if buffers remain, the pointer moves on by one buffer of 32 locations and the remaining count drops by one. Once the count reaches zero the pointer stays where it is, so every later message overwrites the last buffer. A message marked bad records its status but uses up no buffer. There are two interrupt request outputs. One pulses when a valid command addresses the subaddress. The other pulses when the last free buffer is used up.

Top module: `sa_buf_indexer`

## Requirements
- R1: During and right after synchronous reset, `ram_we`, `irq_cmd` and `irq_last` are 0. The pointer, status pointer, remaining count and time tag all reset to 0.
- R2: When `cfg_we` is 1, the block loads the control word, the data pointer and the status pointer. The remaining count is taken from control bits 6..0. The message word offset clears. If a message end arrives in the same cycle, the load wins over its pointer and count update.
- R3: A `word_valid` in cycle t causes a write in cycle t+1 with `ram_we`=1, `ram_wdata`=`word_data` and `ram_addr` = pointer + offset. The offset is the number of words accepted since the last message end or load, taken modulo 32.
- R4: A `msg_done` in cycle t causes a write in cycle t+1 to the status pointer of {2'b00, err, count[4:0], tag[7:0]}. The error is in bit 13, the count in bits 12..8 and the tag in bits 7..0. A count of 32 is stored as 0. If a data word arrives in the same cycle as `msg_done`, the status write wins and that data word is dropped.
- R5: A message end without error, while the remaining count is nonzero, adds 32 to the pointer and subtracts 1 from the count.
- R6: A message end without error, while the count is zero, leaves the pointer unchanged, so the next message writes over the same buffer.
- R7: A message end with `msg_err`=1 changes neither the pointer nor the count.
- R8: The time tag counts `tb_tick` pulses modulo 256. A status word carries the tag value from before any tick in that same cycle.
- R9: `cmd_valid` in cycle t gives a one-cycle `irq_cmd` pulse in t+1 if control bit 8 is set, and no pulse if it is clear.
- R10: A good message end that takes the count from 1 to 0 gives a one-cycle `irq_last` pulse in the next cycle, if control bit 15 is set. Messages ending while the count is already zero give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load control word and pointers |
| cfg_ctrl | input | 16 | Control word (bits 6..0 count, bit 8 command irq enable, bit 15 last-buffer irq enable) |
| cfg_data_ptr | input | 16 | Start address of first buffer |
| cfg_stat_ptr | input | 16 | Status word address |
| cmd_valid | input | 1 | Valid command addressed this subaddress |
| word_valid | input | 1 | Data word strobe |
| word_data | input | 16 | Data word |
| msg_done | input | 1 | Message complete strobe |
| msg_wcnt | input | 6 | Words in the message, 1 to 32 |
| msg_err | input | 1 | Message had an error |
| tb_tick | input | 1 | One pulse per 64 us time unit |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 16 | RAM write data |
| irq_cmd | output | 1 | Subaddress event interrupt request |
| irq_last | output | 1 | Buffers exhausted interrupt request |

## Verification
The bench uses a small count of buffers so that it reaches the freeze. A design that kept advancing would write past the last buffer, and one that froze early would overwrite a buffer too soon. Bad messages come between good ones; a design that advanced on them would shift every later address by 32. A 32-word message checks that the count field wraps to 0 and does not spill into the error bit. The tag is driven past 256 and ticks land in the same cycle as message ends, which exposes a tag that is off by one. A configuration load that coincides with a message end, and a data word that coincides with a message end, check the two priority rules.

// File: rtl/sabi_pkg.sv
package sabi_pkg;
    localparam int unsigned STAT_W   = 16;
    localparam int unsigned CNT_W    = 5;
    localparam int unsigned TAG_W    = 8;
    localparam int unsigned ERR_BIT  = 13;
    localparam int unsigned CMD_IRQ_BIT  = 8;
    localparam int unsigned LAST_IRQ_BIT = 15;

    typedef struct packed {
        logic [1:0]       rsvd;
        logic             err;
        logic [CNT_W-1:0] wcnt;
        logic [TAG_W-1:0] tag;
    } stat_word_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_DATA = 2'd1,
        WR_STAT = 2'd2
    } wr_kind_e;

    function automatic stat_word_t pack_status(input logic err,
                                               input logic [5:0] wcnt,
                                               input logic [TAG_W-1:0] tag);
        stat_word_t s;
        s.rsvd = 2'b00;
        s.err  = err;
        s.wcnt = wcnt[CNT_W-1:0];
        s.tag  = tag;
        return s;
    endfunction
endpackage

// File: rtl/sabi_timebase.sv
module sabi_timebase #(
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [TAG_W-1:0] tag
);
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst)       tag_q <= '0;
        else if (tick) tag_q <= tag_q + 1'b1;
    end

    assign tag = tag_q;

    a_r8_tag_steps: assert property (@(posedge clk) disable iff (rst)
        tick |=> tag_q == $past(tag_q) + 1'b1);
    a_r8_tag_holds: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tag_q));
endmodule

// File: rtl/sabi_index_ctl.sv
module sabi_index_ctl #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CTRL_W = 16,
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned STRIDE = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [ADDR_W-1:0] cfg_data_ptr,
    input  logic [ADDR_W-1:0] cfg_stat_ptr,
    input  logic              cmd_valid,
    input  logic              msg_done,
    input  logic              msg_err,
    output logic [ADDR_W-1:0] data_ptr,
    output logic [ADDR_W-1:0] stat_ptr,
    output logic              irq_cmd,
    output logic              irq_last
);
    import sabi_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);
    localparam logic [IDX_W-1:0]  ONE  = IDX_W'(1);

    logic [CTRL_W-1:0] ctrl_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] ptr_q, sptr_q;
    logic              irq_cmd_q, irq_last_q;
    logic              good_end, can_adv;

    assign good_end = msg_done && !msg_err;
    assign can_adv  = good_end && (idx_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            idx_q  <= '0;
            ptr_q  <= '0;
            sptr_q <= '0;
        end else if (cfg_we) begin
            ctrl_q <= cfg_ctrl;
            idx_q  <= cfg_ctrl[IDX_W-1:0];
            ptr_q  <= cfg_data_ptr;
            sptr_q <= cfg_stat_ptr;
        end else if (can_adv) begin
            idx_q <= idx_q - ONE;
            ptr_q <= ptr_q + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_cmd_q  <= 1'b0;
            irq_last_q <= 1'b0;
        end else begin
            irq_cmd_q  <= cmd_valid && ctrl_q[CMD_IRQ_BIT];
            irq_last_q <= !cfg_we && can_adv && (idx_q == ONE) && ctrl_q[LAST_IRQ_BIT];
        end
    end

    assign data_ptr = ptr_q;
    assign stat_ptr = sptr_q;
    assign irq_cmd  = irq_cmd_q;
    assign irq_last = irq_last_q;

    a_r5_advance: assert property (@(posedge clk) disable iff (rst)
        (msg_done && !msg_err && !cfg_we && idx_q != '0)
        |=> (ptr_q == $past(ptr_q) + STEP) && (idx_q == $past(idx_q) - ONE));
    a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
        (msg_done && !cfg_we && idx_q == '0) |=> $stable(ptr_q) && idx_q == '0);
    a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
        (msg_done && msg_err && !cfg_we) |=> $stable(ptr_q) && $stable(idx_q));
    a_r10_last_once: assert property (@(posedge clk) disable iff (rst)
        irq_last_q |-> idx_q == '0);
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> ptr_q == $past(cfg_data_ptr) && sptr_q == $past(cfg_stat_ptr));
endmodule

// File: rtl/sabi_write_port.sv
module sabi_write_port #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STRIDE = 32,
    parameter int unsigned TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              msg_done,
    input  logic [5:0]        msg_wcnt,
    input  logic              msg_err,
    input  logic [TAG_W-1:0]  tag,
    input  logic [ADDR_W-1:0] data_ptr,
    input  logic [ADDR_W-1:0] stat_ptr,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    import sabi_pkg::*;

    localparam int unsigned OFF_W = $clog2(STRIDE);

    logic [OFF_W-1:0]  off_q;
    wr_kind_e          kind_d, kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    stat_word_t        sw;

    assign sw = pack_status(msg_err, msg_wcnt, tag);

    always_comb begin
        if (msg_done)        kind_d = WR_STAT;
        else if (word_valid) kind_d = WR_DATA;
        else                 kind_d = WR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_we || msg_done) off_q <= '0;
        else if (word_valid)           off_q <= off_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= WR_NONE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            kind_q <= kind_d;
            case (kind_d)
                WR_STAT: begin
                    addr_q <= stat_ptr;
                    data_q <= DATA_W'(sw);
                end
                WR_DATA: begin
                    addr_q <= data_ptr + ADDR_W'(off_q);
                    data_q <= word_data;
                end
                default: begin
                    addr_q <= addr_q;
                    data_q <= data_q;
                end
            endcase
        end
    end

    assign ram_we    = (kind_q != WR_NONE);
    assign ram_addr  = addr_q;
    assign ram_wdata = data_q;

    a_r4_status_write: assert property (@(posedge clk) disable iff (rst)
        msg_done |=> ram_we && ram_addr == $past(stat_ptr) && ram_wdata[15:14] == 2'b00);
    a_r3_data_write: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !msg_done) |=> ram_we && ram_wdata == $past(word_data));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!word_valid && !msg_done) |=> !ram_we);
endmodule

// File: rtl/sa_buf_indexer.sv
module sa_buf_indexer #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CTRL_W = 16,
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned STRIDE = 32,
    parameter int unsigned TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [ADDR_W-1:0] cfg_data_ptr,
    input  logic [ADDR_W-1:0] cfg_stat_ptr,
    input  logic              cmd_valid,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              msg_done,
    input  logic [5:0]        msg_wcnt,
    input  logic              msg_err,
    input  logic              tb_tick,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              irq_cmd,
    output logic              irq_last
);
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] data_ptr, stat_ptr;

    sabi_timebase #(.TAG_W(TAG_W)) u_time (
        .clk(clk), .rst(rst), .tick(tb_tick), .tag(tag)
    );

    sabi_index_ctl #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .IDX_W(IDX_W), .STRIDE(STRIDE)) u_idx (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
        .cfg_data_ptr(cfg_data_ptr), .cfg_stat_ptr(cfg_stat_ptr),
        .cmd_valid(cmd_valid), .msg_done(msg_done), .msg_err(msg_err),
        .data_ptr(data_ptr), .stat_ptr(stat_ptr),
        .irq_cmd(irq_cmd), .irq_last(irq_last)
    );

    sabi_write_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRIDE(STRIDE), .TAG_W(TAG_W)) u_wr (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .word_valid(word_valid), .word_data(word_data),
        .msg_done(msg_done), .msg_wcnt(msg_wcnt), .msg_err(msg_err),
        .tag(tag), .data_ptr(data_ptr), .stat_ptr(stat_ptr),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    a_r9_irq_cmd_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        irq_cmd |-> $past(cmd_valid));
    a_r10_irq_last_needs_end: assert property (@(posedge clk) disable iff (rst)
        irq_last |-> $past(msg_done) && !$past(msg_err));
endmodule

// File: tb/sa_buf_indexer_tb.sv
module sa_buf_indexer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [15:0] cfg_ctrl, cfg_data_ptr, cfg_stat_ptr;
    logic        cmd_valid, word_valid, msg_done, msg_err, tb_tick;
    logic [15:0] word_data;
    logic [5:0]  msg_wcnt;
    logic        ram_we, irq_cmd, irq_last;
    logic [15:0] ram_addr, ram_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_ptr, m_sptr, m_ctrl;
    logic [6:0]  m_idx;
    logic [7:0]  m_tag;
    logic [4:0]  m_off;

    always #5 clk = ~clk;

    sa_buf_indexer u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
        .cfg_data_ptr(cfg_data_ptr), .cfg_stat_ptr(cfg_stat_ptr),
        .cmd_valid(cmd_valid), .word_valid(word_valid), .word_data(word_data),
        .msg_done(msg_done), .msg_wcnt(msg_wcnt), .msg_err(msg_err), .tb_tick(tb_tick),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .irq_cmd(irq_cmd), .irq_last(irq_last)
    );

    function automatic logic [15:0] exp_status(input logic err, input logic [5:0] n,
                                               input logic [7:0] tag);
        return {2'b00, err, n[4:0], tag};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        cfg_we = 0; cmd_valid = 0; word_valid = 0; msg_done = 0; msg_err = 0; tb_tick = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic load(input logic [15:0] ctrl, input logic [15:0] p, input logic [15:0] sp);
        cfg_we = 1; cfg_ctrl = ctrl; cfg_data_ptr = p; cfg_stat_ptr = sp;
        step(); clear_in();
        m_ctrl = ctrl; m_idx = ctrl[6:0]; m_ptr = p; m_sptr = sp; m_off = 0;
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tb_tick = 1; step(); m_tag++;
        end
        clear_in();
    endtask

    // one message: n data words then a message end
    task automatic send_msg(input int n, input logic err, input bit rnd_tick);
        logic exp_last;
        for (int i = 0; i < n; i++) begin
            word_valid = 1; word_data = 16'($urandom);
            tb_tick = rnd_tick ? 1'($urandom) : 1'b0;
            step();
            chk("R3 data we", ram_we, 1);
            chk("R3 data addr", ram_addr, m_ptr + 16'(m_off));
            chk("R3 data value", ram_wdata, word_data);
            m_off++;
            if (tb_tick) m_tag++;
            clear_in();
        end
        msg_done = 1; msg_err = err; msg_wcnt = 6'(n);
        tb_tick = rnd_tick ? 1'($urandom) : 1'b0;
        step();
        chk("R4 status addr", ram_addr, m_sptr);
        chk("R4 R8 status word", ram_wdata, exp_status(err, 6'(n), m_tag));
        exp_last = 0;
        if (!err && m_idx != 0) begin
            exp_last = (m_idx == 1) && m_ctrl[15];
            m_idx--; m_ptr += 16'd32;
        end
        chk("R10 irq_last", irq_last, exp_last);
        if (tb_tick) m_tag++;
        m_off = 0;
        clear_in();
        step();
        chk("R10 irq_last single pulse", irq_last, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_in(); cfg_ctrl = 0; cfg_data_ptr = 0; cfg_stat_ptr = 0;
        word_data = 0; msg_wcnt = 0;
        rst = 1;
        step(); step();
        chk("R1 ram_we in reset", ram_we, 0);
        chk("R1 irq_cmd in reset", irq_cmd, 0);
        rst = 0;
        step();
        chk("R1 ram_we after reset", ram_we, 0);
        chk("R1 irq_last after reset", irq_last, 0);
        m_ptr = 0; m_sptr = 0; m_ctrl = 0; m_idx = 0; m_tag = 0; m_off = 0;
        // reset state: one good message writes at address 0, status at 0, no advance
        send_msg(2, 0, 0);

        // R5 R6 R10: two buffers then freeze
        load(16'h8102, 16'h1000, 16'h0F00);
        send_msg(3, 0, 1);   // R5 advance
        send_msg(5, 1, 1);   // R7 error: no advance
        send_msg(4, 0, 1);   // R5 last buffer, R10 irq
        send_msg(6, 0, 1);   // R6 frozen
        send_msg(2, 0, 1);   // R6 frozen again, overwrite same buffer

        // R4: 32-word message stores count 0, error bit separate
        load(16'h0003, 16'h2000, 16'h0E00);
        send_msg(32, 1, 0);
        send_msg(32, 0, 0);

        // R4: data word coincident with message end is dropped
        word_valid = 1; word_data = 16'hBEEF; step();
        m_off++; clear_in();
        word_valid = 1; word_data = 16'hDEAD; msg_done = 1; msg_wcnt = 6'd2; step();
        chk("R4 status wins addr", ram_addr, m_sptr);
        chk("R4 status wins data", ram_wdata, exp_status(0, 6'd2, m_tag));
        m_idx--; m_ptr += 16'd32; m_off = 0; clear_in();
        step();
        chk("R4 dropped word not written", ram_we, 0);

        // R2: load coincides with message end
        msg_done = 1; msg_wcnt = 6'd1; cfg_we = 1;
        cfg_ctrl = 16'h0001; cfg_data_ptr = 16'h3000; cfg_stat_ptr = 16'h0D00;
        step();
        chk("R2 status uses old pointer", ram_addr, m_sptr);
        clear_in();
        m_ctrl = 16'h0001; m_idx = 1; m_ptr = 16'h3000; m_sptr = 16'h0D00; m_off = 0;
        step();
        send_msg(1, 0, 0);   // R2 pointer from load, count 1 -> 0, no irq (bit15 clear)

        // R9 command interrupt
        cmd_valid = 1; step(); clear_in();
        chk("R9 no irq with bit8 clear", irq_cmd, 0);
        load(16'h0100, 16'h4000, 16'h0C00);
        cmd_valid = 1; step(); clear_in();
        chk("R9 irq_cmd pulse", irq_cmd, 1);
        step();
        chk("R9 irq_cmd one cycle", irq_cmd, 0);

        // R8 tag wrap
        idle_ticks(300);
        send_msg(1, 0, 0);

        // random mix
        load(16'h8000 | 16'd20, 16'h5000, 16'h0B00);
        for (int k = 0; k < 60; k++) begin
            if (($urandom % 16) == 0)
                load(16'h8000 | 16'($urandom % 5), 16'($urandom) & 16'hFFE0, 16'($urandom));
            send_msg(1 + int'($urandom % 32), 1'(($urandom % 4) == 0), 1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule